// File: doc/BRIEF.md
# Bidirectional Bus Transfer Register

This block is an eight-stage storage register placed between two 8-bit buses, A and B, each modelled as a separate input, output and output-enable. It copies a byte from whichever bus is the input side to the register, where it shows on the opposite bus. It can also shift a serial stream in one bit per register-clock edge and present the result in parallel, or hold its contents while both sides stay quiet.

The register clock is a slow control input, not the system clock. The block samples it through a two-flop synchroniser and acts on its rising edge. In parallel mode an asynchronous option bypasses the edge: the input bus is copied on every system clock cycle for as long as that option is set. The top stage leaves the block as a serial output, so several registers can be chained through their serial inputs into a longer shift register.

Top module: `bus_xfer_reg`

## Requirements
- R1: While `rst_n` is low, both `a_oe` and `b_oe` are 0. After a clock edge with `rst_n` low, all stages hold 0 and `ser_out` is 0.
- R2: With `par_sel`=1 and `async_sel`=0, the register loads only on a rising edge of `reg_clk`. The new value is on the output bus after the third system clock edge, counting from the first edge that samples `reg_clk` high. Without such an edge the contents do not change.
- R3: With `par_sel`=1 and `async_sel`=1, the input-side bus is copied into the register on every system clock edge, with no `reg_clk` activity needed.
- R4: With `dir_a2b`=1, bus A is the parallel source and `b_oe`=1. With `dir_a2b`=0, bus B is the source, `b_oe`=0 and `a_oe` equals `a_en`. Both enables are never 1 together.
- R5: With `dir_a2b`=1 and `a_en`=0 in parallel mode, every stage keeps its value and `a_in` is ignored.
- R6: With `dir_a2b`=0 and `a_en`=0, bus A is not driven (`a_oe`=0), and parallel loads from bus B still take place.
- R7: With `par_sel`=0, each rising `reg_clk` edge moves stage i to stage i+1 and puts `ser_in` into stage 0 (bit 0 of the buses). `async_sel` has no effect, so exactly one shift happens per edge.
- R8: In serial mode the contents appear on bus B when `dir_a2b`=1, and on bus A when `dir_a2b`=0 and `a_en`=1. `ser_out` always equals stage 7 (bus bit 7), so a bit shifted in appears on `ser_out` after eight edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_clk | input | 1 | Register clock, sampled through a synchroniser |
| a_en | input | 1 | Enables the A side for input or output |
| async_sel | input | 1 | 1: parallel load without a clock edge |
| dir_a2b | input | 1 | 1: A is the source and B the output; 0: the reverse |
| par_sel | input | 1 | 1: parallel load; 0: serial shift |
| ser_in | input | 1 | Serial data into stage 0 |
| a_in | input | 8 | Bus A input value |
| a_out | output | 8 | Bus A driven value |
| a_oe | output | 1 | Bus A output enable |
| b_in | input | 8 | Bus B input value |
| b_out | output | 8 | Bus B driven value |
| b_oe | output | 1 | Bus B output enable |
| ser_out | output | 1 | Stage 7, used for cascading |

## Verification
A corrupted stage shows on the enabled output bus and, for stage 7, on `ser_out`. It shows as soon as the next load or shift has settled, which for clocked operations is three system cycles after `reg_clk` rises. Some corruption is hidden while both enables are low. The bench then moves to a hold setting with B enabled and reads the value back there. A wrong decode of the mode is caught one load later, when the bus value differs from the byte the requirements predict. Wrong synchroniser depth or edge detection moves the cycle in which that byte appears.

// File: rtl/bxr_pkg.sv
// Shared types for the bus transfer register.
package bxr_pkg;
    // Next-state selection for the storage stages.
    typedef enum logic [1:0] {
        OP_HOLD   = 2'd0,
        OP_LOAD_A = 2'd1,
        OP_LOAD_B = 2'd2,
        OP_SHIFT  = 2'd3
    } bxr_op_e;
endpackage

// File: rtl/bxr_edge_sync.sv
// Synchronises the slow register clock into the system clock domain and
// emits a one-cycle pulse per rising edge. Assumes reg_clk high and low
// phases each last at least two system cycles.
module bxr_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_in,
    output logic rise
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    // Synchroniser chain plus delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], raw_in};
            prev_q <= sync_q[STAGES-1];
        end
    end

    // Edge pulse from the synchronised level.
    assign rise = sync_q[STAGES-1] & ~prev_q;

    // R2: an edge pulse never lasts two cycles.
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/bxr_mode_dec.sv
// Decodes the control pins into a next-state operation and a fire strobe.
// Assumes the edge pulse is already in the system clock domain.
module bxr_mode_dec
    import bxr_pkg::*;
(
    input  logic    par_sel,
    input  logic    async_sel,
    input  logic    dir_a2b,
    input  logic    a_en,
    input  logic    edge_rise,
    output bxr_op_e op,
    output logic    fire
);
    // Pick the data source for the stages.
    always_comb begin
        if (!par_sel)
            op = OP_SHIFT;
        else if (!dir_a2b)
            op = OP_LOAD_B;
        else if (a_en)
            op = OP_LOAD_A;
        else
            op = OP_HOLD;
    end

    // Async loads only apply in parallel mode; serial always waits for an edge.
    assign fire = par_sel ? (async_sel | edge_rise) : edge_rise;
endmodule

// File: rtl/bxr_stage_array.sv
// The storage stages with per-bit next-state selection. Stage 0 takes the
// serial input; shifting moves data toward the highest stage.
module bxr_stage_array
    import bxr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  bxr_op_e          op,
    input  logic             fire,
    input  logic             ser_in,
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] nxt;

    // Per-stage multiplexer selecting hold, A, B or the neighbour below.
    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
        logic shift_src;
        if (i == 0) begin : g_first
            assign shift_src = ser_in;
        end else begin : g_rest
            assign shift_src = q[i-1];
        end
        assign nxt[i] = (op == OP_LOAD_A) ? a_in[i] :
                        (op == OP_LOAD_B) ? b_in[i] :
                        (op == OP_SHIFT)  ? shift_src : q[i];
    end

    // Stage registers, updated only on a fire strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (fire)
            q <= nxt;
    end

    // R7: a shift moves every stage up one and brings in the serial bit.
    a_r7_shift: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && op == OP_SHIFT) |=>
            (q[0] == $past(ser_in)) && (q[WIDTH-1:1] == $past(q[WIDTH-2:0])));
    // R5: in hold the stages keep their value whatever the buses carry.
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_HOLD) |=> $stable(q));
endmodule

// File: rtl/bus_xfer_reg.sv
// Eight-stage register between two buses with parallel, async parallel
// and serial modes. Assumes each bus's tri-state is resolved outside this
// block, using the separate input, output and output-enable signals.
module bus_xfer_reg
    import bxr_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_clk,
    input  logic             a_en,
    input  logic             async_sel,
    input  logic             dir_a2b,
    input  logic             par_sel,
    input  logic             ser_in,
    input  logic [WIDTH-1:0] a_in,
    output logic [WIDTH-1:0] a_out,
    output logic             a_oe,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] b_out,
    output logic             b_oe,
    output logic             ser_out
);
    localparam int MSB = WIDTH - 1;

    logic             edge_rise;
    logic             fire;
    bxr_op_e          op;
    logic [WIDTH-1:0] q;

    bxr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_in (reg_clk),
        .rise   (edge_rise)
    );

    bxr_mode_dec u_dec (
        .par_sel   (par_sel),
        .async_sel (async_sel),
        .dir_a2b   (dir_a2b),
        .a_en      (a_en),
        .edge_rise (edge_rise),
        .op        (op),
        .fire      (fire)
    );

    bxr_stage_array #(.WIDTH(WIDTH)) u_stages (
        .clk    (clk),
        .rst_n  (rst_n),
        .op     (op),
        .fire   (fire),
        .ser_in (ser_in),
        .a_in   (a_in),
        .b_in   (b_in),
        .q      (q)
    );

    // Bus drivers: data always presented, enables follow direction and reset.
    assign a_out   = q;
    assign b_out   = q;
    assign b_oe    = rst_n & dir_a2b;
    assign a_oe    = rst_n & ~dir_a2b & a_en;
    assign ser_out = q[MSB];

    // R4: the two buses are never driven together.
    always_comb begin
        a_r4_oe_exclusive: assert (!(a_oe && b_oe));
    end
    // R1: both buses released during reset.
    always_comb begin
        if (!rst_n) a_r1_release: assert (!a_oe && !b_oe);
    end
    // R2: a synchronous parallel setting without an edge leaves the stages alone.
    a_r2_no_edge_no_load: assert property (@(posedge clk) disable iff (!rst_n)
        (par_sel && !async_sel && !edge_rise) |=> $stable(q));
    // R3: async parallel load from B lands after one system cycle.
    a_r3_async_from_b: assert property (@(posedge clk) disable iff (!rst_n)
        (par_sel && async_sel && !dir_a2b) |=> (b_out == $past(b_in)));
endmodule

// File: tb/sim_bus_xfer_reg.sv
`timescale 1ns/1ps
module sim_bus_xfer_reg;
    localparam int W = 8;
    // {par, async, dir, aen, ser, a[8], b[8], expected[8]}
    localparam int VW = 29;
    localparam int NV = 10;
    localparam logic [VW-1:0] VEC [NV] = '{
        {1'b1,1'b0,1'b1,1'b1,1'b0, 8'hA5, 8'h3C, 8'hA5}, // R2 R4 load from A
        {1'b1,1'b0,1'b1,1'b0,1'b0, 8'hFF, 8'h00, 8'hA5}, // R5 hold, A ignored
        {1'b1,1'b0,1'b0,1'b1,1'b0, 8'h11, 8'h3C, 8'h3C}, // R4 load from B
        {1'b1,1'b0,1'b0,1'b0,1'b0, 8'h22, 8'h81, 8'h81}, // R6 B load, A quiet
        {1'b1,1'b0,1'b1,1'b0,1'b0, 8'h00, 8'h55, 8'h81}, // R5 read back on B
        {1'b0,1'b0,1'b1,1'b1,1'b1, 8'hEE, 8'hEE, 8'h03}, // R7 shift in 1
        {1'b0,1'b1,1'b1,1'b1,1'b0, 8'hEE, 8'hEE, 8'h06}, // R7 async ignored
        {1'b0,1'b0,1'b0,1'b1,1'b1, 8'h00, 8'h00, 8'h0D}, // R8 serial on A
        {1'b0,1'b0,1'b1,1'b0,1'b1, 8'h00, 8'h00, 8'h1B}, // R8 serial on B
        {1'b1,1'b1,1'b1,1'b1,1'b0, 8'h5A, 8'h00, 8'h5A}  // R3 async from A
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_clk = 1'b0, a_en = 1'b0, async_sel = 1'b0, dir_a2b = 1'b0;
    logic par_sel = 1'b0, ser_in = 1'b0;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic [W-1:0] a_out, b_out;
    logic a_oe, b_oe, ser_out;
    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    bus_xfer_reg u0 (
        .clk(clk), .rst_n(rst_n), .reg_clk(reg_clk), .a_en(a_en),
        .async_sel(async_sel), .dir_a2b(dir_a2b), .par_sel(par_sel),
        .ser_in(ser_in), .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe), .ser_out(ser_out)
    );

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic pulse_reg_clk();
        reg_clk = 1'b1;
        repeat (4) @(negedge clk);
        reg_clk = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        #(200000 * 4);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R1: reset state.
        repeat (3) @(negedge clk);
        chk("R1 a_oe", {7'd0, a_oe}, 8'd0);
        chk("R1 b_oe", {7'd0, b_oe}, 8'd0);
        dir_a2b = 1'b1;
        chk("R1 b_oe in reset", {7'd0, b_oe}, 8'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 stages clear", b_out, 8'h00);
        chk("R1 ser_out", {7'd0, ser_out}, 8'd0);

        // Table walk.
        for (int i = 0; i < NV; i++) begin
            logic [W-1:0] e;
            {par_sel, async_sel, dir_a2b, a_en, ser_in, a_in, b_in, e} = VEC[i];
            pulse_reg_clk();
            chk("R4 b_oe", {7'd0, b_oe}, {7'd0, dir_a2b});
            chk("R4 a_oe", {7'd0, a_oe}, {7'd0, ~dir_a2b & a_en});
            if (b_oe) chk("R2/R8 data on B", b_out, e);
            else if (a_oe) chk("R4/R8 data on A", a_out, e);
            chk("R8 ser_out", {7'd0, ser_out}, {7'd0, e[W-1]});
        end

        // R2: no load without an edge, then the exact latency of the edge.
        par_sel = 1'b1; async_sel = 1'b0; dir_a2b = 1'b1; a_en = 1'b1; a_in = 8'h77;
        repeat (6) @(negedge clk);
        chk("R2 no edge", b_out, 8'h5A);
        reg_clk = 1'b1;
        repeat (2) @(negedge clk);
        chk("R2 before third edge", b_out, 8'h5A);
        @(negedge clk);
        chk("R2 after third edge", b_out, 8'h77);
        repeat (3) @(negedge clk);
        reg_clk = 1'b0;
        repeat (4) @(negedge clk);

        // R3 and R6: async loads from B every cycle, A not driven when a_en low.
        async_sel = 1'b1; dir_a2b = 1'b0; a_en = 1'b0; b_in = 8'hC3;
        @(negedge clk);
        chk("R6 a_oe low", {7'd0, a_oe}, 8'd0);
        a_en = 1'b1;
        #0;
        chk("R3 async first cycle", a_out, 8'hC3);
        b_in = 8'h24;
        @(negedge clk);
        chk("R3 async follows bus", a_out, 8'h24);

        // R7/R8: cascade, eight ones reach ser_out only on the eighth shift.
        async_sel = 1'b0; dir_a2b = 1'b1; a_in = 8'h00;
        pulse_reg_clk();
        chk("R2 cleared", b_out, 8'h00);
        par_sel = 1'b0; ser_in = 1'b1; async_sel = 1'b1;
        for (int k = 0; k < 7; k++) pulse_reg_clk();
        chk("R8 ser_out after 7", {7'd0, ser_out}, 8'd0);
        chk("R7 seven shifts", b_out, 8'h7F);
        pulse_reg_clk();
        chk("R8 ser_out after 8", {7'd0, ser_out}, 8'd1);
        chk("R7 eight shifts", b_out, 8'hFF);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule